// File: doc/BRIEF.md
# Instruction Prefetch Ring Cell

This block is one position in a circular chain of instruction prefetch cells that together feed a statically scheduled processor. Each cell owns one slot of the instruction address space: the low address bits are fixed by the cell's position, and only the high-order part of the address travels between neighbours. A cell fetches one instruction word from instruction memory, holds it, and places it on the shared instruction bus when the execution token reaches it. Sequential code runs by passing the token and the fetch requests from each cell to its right neighbour.

A cell can also be armed from the controller above the ring as the destination of a later multi-way branch. In that case it records a branch tag and a condition pattern. When a branch with that tag is broadcast, the cell compares the live condition bits with its pattern. On a match it takes the token. On a mismatch it gives up its armed role and resumes ordinary sequential prefetching. A cell whose token arrives before its word does stalls the datapath until the word lands. A response that belongs to a fetch that has been superseded is discarded through a one-bit request tag.

Top module: `pfring_cell`

## Requirements
- R1: While reset is high, and in the cycle after it, the cell drives no memory request, no instruction, no stall, no fetch request to the right and no token to the right.
- R2: When a fetch starts, the cell raises `mem_req` in the same cycle. `mem_addr` is `{high part, CELL_IDX}`, with the high part in the upper HI_W bits and the cell index in the low IDX_W bits.
- R3: In the cycle after any fetch starts, including one satisfied without a memory request, `right_start` is high and `right_hi` carries the fetched high part. The last cell of the ring (CELL_IDX = 2^IDX_W-1) adds one, modulo 2^HI_W.
- R4: A left fetch request that reaches an unarmed cell while that cell is still busy abandons the earlier fetch and issues the new address. A late response carrying the old request tag is ignored.
- R5: An arming request from the top always starts a fetch of `top_hi` and stores the tag and pattern. An armed cell ignores left fetch requests. When top and left requests arrive in the same cycle, the top address is used.
- R6: When the token reaches a cell whose word has not arrived, `freeze` stays high every cycle until the word arrives. The word is then delivered with `ibus_valid` high.
- R7: When the token reaches a cell holding its word, that word is on `ibus_data` with `ibus_valid` high in the next cycle. `right_act` is high in the cycle after delivery.
- R8: On a branch broadcast whose tag equals the stored tag, an armed cell whose pattern does not match clears its armed role and fetches `left_hi`. A broadcast with a different tag has no effect.
- R9: A fetch request for the high part already held or being fetched, while the slot is not empty, issues no memory request.
- R10: A branch broadcast in the cycle after delivery suppresses `right_act`.
- R11: The pattern holds a care bit and a value bit for each condition bit. It matches when every cared condition bit equals its value bit. A matching armed cell takes the token and, after delivering, returns to the unarmed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| left_start | input | 1 | Fetch request from the left neighbour |
| left_hi | input | HI_W | High address part from the left neighbour |
| left_act | input | 1 | Execution token from the left neighbour |
| right_start | output | 1 | Fetch request to the right neighbour |
| right_hi | output | HI_W | High address part to the right neighbour |
| right_act | output | 1 | Execution token to the right neighbour |
| top_sel | input | 1 | Arming fetch request addressed to this cell |
| top_hi | input | HI_W | High address part of the arming fetch |
| top_label | input | LABEL_W | Branch tag to store |
| top_care | input | NCOND | Care bits of the condition pattern |
| top_val | input | NCOND | Value bits of the condition pattern |
| jump_valid | input | 1 | Branch broadcast strobe |
| jump_label | input | LABEL_W | Tag of the broadcast branch |
| cond_bits | input | NCOND | Live condition bits |
| mem_req | output | 1 | Instruction memory request |
| mem_addr | output | HI_W+IDX_W | Request address |
| mem_tag | output | 1 | Request tag |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_tag | input | 1 | Tag of the response |
| mem_rsp_data | input | INSTR_W | Returned instruction word |
| ibus_valid | output | 1 | Instruction bus valid |
| ibus_data | output | INSTR_W | Instruction bus word |
| freeze | output | 1 | Datapath stall |

## Verification
The bench builds the cell with HI_W=6, IDX_W=2, CELL_IDX=3, LABEL_W=2, NCOND=3 and INSTR_W=16, against a memory model with a three-cycle response. Placing the cell at the last ring position makes the wrap increment of the forwarded address observable. The three-cycle latency leaves room for a superseding request while the first response is still in flight, so the stale response path is exercised. Three condition bits are enough to arm patterns that mix cared and don't-care positions, and a two-bit tag lets the bench broadcast a different tag and check that it has no effect.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_BUSY  = 2'd1,
        ST_READY = 2'd2
    } slot_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TOP  = 2'd1,
        SRC_JUMP = 2'd2,
        SRC_LEFT = 2'd3
    } fetch_src_e;

    // Priority: arming from the top, then mismatch fallback, then the left chain.
    function automatic fetch_src_e pick_src(input logic top_req,
                                            input logic miss,
                                            input logic left_req,
                                            input logic armed);
        if (top_req)
            return SRC_TOP;
        else if (miss)
            return SRC_JUMP;
        else if (left_req && !armed)
            return SRC_LEFT;
        else
            return SRC_NONE;
    endfunction

endpackage

// File: rtl/pf_match.sv
module pf_match #(
    parameter int LABEL_W = 2,
    parameter int NCOND   = 4
) (
    input  logic               armed,
    input  logic [LABEL_W-1:0] lbl_q,
    input  logic [NCOND-1:0]   care_q,
    input  logic [NCOND-1:0]   val_q,
    input  logic               jump_valid,
    input  logic [LABEL_W-1:0] jump_label,
    input  logic [NCOND-1:0]   cond_bits,
    output logic               hit,
    output logic               miss
);
    logic tag_eq;
    logic pat_ok;

    always_comb begin
        tag_eq = jump_valid && armed && (jump_label == lbl_q);
        pat_ok = ((cond_bits ^ val_q) & care_q) == '0;
        hit    = tag_eq && pat_ok;
        miss   = tag_eq && !pat_ok;
    end
endmodule

// File: rtl/pf_fetch.sv
module pf_fetch
    import pfc_pkg::*;
#(
    parameter int HI_W     = 14,
    parameter int IDX_W    = 5,
    parameter int CELL_IDX = 0,
    parameter int INSTR_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [HI_W-1:0]       go_hi,
    input  logic                  deliver,
    input  logic                  mem_rsp_valid,
    input  logic                  mem_rsp_tag,
    input  logic [INSTR_W-1:0]    mem_rsp_data,
    output logic                  mem_req,
    output logic [HI_W+IDX_W-1:0] mem_addr,
    output logic                  mem_tag,
    output logic                  busy,
    output logic                  ready,
    output logic [HI_W-1:0]       hi_q,
    output logic [INSTR_W-1:0]    data_q
);
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(CELL_IDX);

    slot_state_e st_q;
    slot_state_e st_after;
    logic        tag_q;
    logic        skip;
    logic        accept;

    always_comb begin
        st_after = deliver ? ST_EMPTY : st_q;
        skip     = (st_after != ST_EMPTY) && (go_hi == hi_q);
        mem_req  = go && !skip;
        mem_addr = {go_hi, SLOT};
        mem_tag  = ~tag_q;
        accept   = (st_q == ST_BUSY) && mem_rsp_valid && (mem_rsp_tag == tag_q);
        busy     = (st_q == ST_BUSY);
        ready    = (st_q == ST_READY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_EMPTY;
            tag_q  <= 1'b0;
            hi_q   <= '0;
            data_q <= '0;
        end else if (mem_req) begin
            st_q  <= ST_BUSY;
            tag_q <= ~tag_q;
            hi_q  <= go_hi;
        end else if (deliver) begin
            st_q <= ST_EMPTY;
        end else if (accept) begin
            st_q   <= ST_READY;
            data_q <= mem_rsp_data;
        end
    end
endmodule

// File: rtl/pf_activate.sv
module pf_activate (
    input  logic clk,
    input  logic rst,
    input  logic act_set,
    input  logic busy,
    input  logic ready,
    input  logic jump_valid,
    output logic deliver,
    output logic freeze,
    output logic act_right
);
    logic act_q;
    logic deliv_q;

    always_comb begin
        deliver   = act_q && ready;
        freeze    = act_q && busy;
        act_right = deliv_q && !jump_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            deliv_q <= 1'b0;
        end else begin
            deliv_q <= deliver;
            if (deliver)
                act_q <= 1'b0;
            else if (act_set)
                act_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pfring_cell.sv
module pfring_cell
    import pfc_pkg::*;
#(
    parameter int HI_W     = 14,
    parameter int IDX_W    = 5,
    parameter int CELL_IDX = 0,
    parameter int LABEL_W  = 2,
    parameter int NCOND    = 4,
    parameter int INSTR_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  left_start,
    input  logic [HI_W-1:0]       left_hi,
    input  logic                  left_act,
    output logic                  right_start,
    output logic [HI_W-1:0]       right_hi,
    output logic                  right_act,
    input  logic                  top_sel,
    input  logic [HI_W-1:0]       top_hi,
    input  logic [LABEL_W-1:0]    top_label,
    input  logic [NCOND-1:0]      top_care,
    input  logic [NCOND-1:0]      top_val,
    input  logic                  jump_valid,
    input  logic [LABEL_W-1:0]    jump_label,
    input  logic [NCOND-1:0]      cond_bits,
    output logic                  mem_req,
    output logic [HI_W+IDX_W-1:0] mem_addr,
    output logic                  mem_tag,
    input  logic                  mem_rsp_valid,
    input  logic                  mem_rsp_tag,
    input  logic [INSTR_W-1:0]    mem_rsp_data,
    output logic                  ibus_valid,
    output logic [INSTR_W-1:0]    ibus_data,
    output logic                  freeze
);
    localparam int  LAST_IDX = (1 << IDX_W) - 1;
    localparam bit  WRAP     = (CELL_IDX == LAST_IDX);

    typedef struct packed {
        logic [LABEL_W-1:0] label;
        logic [NCOND-1:0]   care;
        logic [NCOND-1:0]   val;
    } arm_t;

    logic            target_q;
    arm_t            arm_q;
    logic            start_q;
    logic            hit;
    logic            miss;
    logic            deliver;
    logic            busy;
    logic            ready;
    logic            go;
    logic [HI_W-1:0] go_hi;
    logic [HI_W-1:0] hi_q;
    logic            armed_now;
    fetch_src_e      src;

    pf_match #(.LABEL_W(LABEL_W), .NCOND(NCOND)) u_match (
        .armed      (target_q),
        .lbl_q      (arm_q.label),
        .care_q     (arm_q.care),
        .val_q      (arm_q.val),
        .jump_valid (jump_valid),
        .jump_label (jump_label),
        .cond_bits  (cond_bits),
        .hit        (hit),
        .miss       (miss)
    );

    always_comb begin
        armed_now = target_q && !deliver;
        src       = pick_src(top_sel, miss, left_start, armed_now);
        go        = (src != SRC_NONE);
        go_hi     = (src == SRC_TOP) ? top_hi : left_hi;
    end

    pf_fetch #(
        .HI_W(HI_W), .IDX_W(IDX_W), .CELL_IDX(CELL_IDX), .INSTR_W(INSTR_W)
    ) u_fetch (
        .clk           (clk),
        .rst           (rst),
        .go            (go),
        .go_hi         (go_hi),
        .deliver       (deliver),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_tag   (mem_rsp_tag),
        .mem_rsp_data  (mem_rsp_data),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_tag       (mem_tag),
        .busy          (busy),
        .ready         (ready),
        .hi_q          (hi_q),
        .data_q        (ibus_data)
    );

    pf_activate u_act (
        .clk        (clk),
        .rst        (rst),
        .act_set    (left_act || hit),
        .busy       (busy),
        .ready      (ready),
        .jump_valid (jump_valid),
        .deliver    (deliver),
        .freeze     (freeze),
        .act_right  (right_act)
    );

    assign ibus_valid  = deliver;
    assign right_start = start_q;

    generate
        if (WRAP) begin : g_wrap
            assign right_hi = hi_q + 1'b1;
        end else begin : g_pass
            assign right_hi = hi_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= 1'b0;
            arm_q    <= '0;
            start_q  <= 1'b0;
        end else begin
            start_q <= go;
            if (src == SRC_TOP) begin
                target_q <= 1'b1;
                arm_q    <= '{label: top_label, care: top_care, val: top_val};
            end else if (src == SRC_JUMP || deliver) begin
                target_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pfring_cell_chk.sv
module pfring_cell_chk (
    input logic clk,
    input logic rst,
    input logic mem_req,
    input logic right_start,
    input logic right_act,
    input logic ibus_valid,
    input logic freeze,
    input logic jump_valid,
    input logic mem_rsp_valid,
    input logic left_start,
    input logic top_sel,
    input logic target_q,
    input logic deliver
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!ibus_valid && !freeze && !right_start && !right_act));

    assert_req_chains_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> right_start);

    assert_armed_ignores_left_R5: assert property (@(posedge clk) disable iff (rst)
        (left_start && !top_sel && !jump_valid && target_q && !deliver) |-> !mem_req);

    assert_stall_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        freeze |-> !ibus_valid);

    assert_stall_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (freeze && !mem_rsp_valid) |=> freeze);

    assert_token_moves_R7: assert property (@(posedge clk) disable iff (rst)
        ibus_valid |=> (right_act || jump_valid));
endmodule

bind pfring_cell pfring_cell_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .mem_req       (mem_req),
    .right_start   (right_start),
    .right_act     (right_act),
    .ibus_valid    (ibus_valid),
    .freeze        (freeze),
    .jump_valid    (jump_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .left_start    (left_start),
    .top_sel       (top_sel),
    .target_q      (target_q),
    .deliver       (deliver)
);

// File: tb/tb_pfring_cell.sv
`timescale 1ns/1ps
module tb_pfring_cell;
    localparam int HI_W = 6, IDX_W = 2, CELL_IDX = 3, LABEL_W = 2, NCOND = 3, INSTR_W = 16;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic left_start = 0, left_act = 0, top_sel = 0, jump_valid = 0;
    logic [HI_W-1:0] left_hi = '0, top_hi = '0;
    logic [LABEL_W-1:0] top_label = '0, jump_label = '0;
    logic [NCOND-1:0] top_care = '0, top_val = '0, cond_bits = '0;
    logic right_start, right_act, mem_req, mem_tag, ibus_valid, freeze;
    logic [HI_W-1:0] right_hi;
    logic [HI_W+IDX_W-1:0] mem_addr;
    logic [INSTR_W-1:0] ibus_data;
    logic mem_rsp_valid, mem_rsp_tag;
    logic [INSTR_W-1:0] mem_rsp_data;

    logic [LAT-1:0] pv;
    logic [LAT-1:0] pt;
    logic [HI_W+IDX_W-1:0] pa [LAT];

    int checks = 0;
    int errors = 0;
    logic [INSTR_W-1:0] expq [$];

    pfring_cell #(.HI_W(HI_W), .IDX_W(IDX_W), .CELL_IDX(CELL_IDX),
                  .LABEL_W(LABEL_W), .NCOND(NCOND), .INSTR_W(INSTR_W)) dut (
        .clk(clk), .rst(rst), .left_start(left_start), .left_hi(left_hi), .left_act(left_act),
        .right_start(right_start), .right_hi(right_hi), .right_act(right_act),
        .top_sel(top_sel), .top_hi(top_hi), .top_label(top_label), .top_care(top_care),
        .top_val(top_val), .jump_valid(jump_valid), .jump_label(jump_label),
        .cond_bits(cond_bits), .mem_req(mem_req), .mem_addr(mem_addr), .mem_tag(mem_tag),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
        .ibus_valid(ibus_valid), .ibus_data(ibus_data), .freeze(freeze));

    function automatic logic [INSTR_W-1:0] word_of(input logic [HI_W-1:0] hi);
        return {8'hA5, hi, 2'(CELL_IDX)};
    endfunction

    // Fixed-latency instruction memory
    always @(posedge clk) begin
        if (rst) begin
            pv <= '0;
            pt <= '0;
        end else begin
            pv[0] <= mem_req;
            pt[0] <= mem_tag;
            pa[0] <= mem_addr;
            for (int i = 1; i < LAT; i++) begin
                pv[i] <= pv[i-1];
                pt[i] <= pt[i-1];
                pa[i] <= pa[i-1];
            end
        end
    end
    assign mem_rsp_valid = pv[LAT-1];
    assign mem_rsp_tag   = pt[LAT-1];
    assign mem_rsp_data  = {8'hA5, pa[LAT-1]};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && ibus_valid) begin
            if (expq.size() == 0)
                chk(1'b0, "R7 unexpected word", int'(ibus_data), 0);
            else begin
                logic [INSTR_W-1:0] e;
                e = expq.pop_front();
                chk(ibus_data == e, "R7 bus word", int'(ibus_data), int'(e));
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        left_start = 0; left_act = 0; top_sel = 0; jump_valid = 0;
        #0.5;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wait_bus(input string req);
        int n = 0;
        while (!ibus_valid && n < 12) begin
            tick();
            n++;
        end
        chk(ibus_valid, req, int'(ibus_valid), 1);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #0.5;
        chk(!mem_req && !ibus_valid && !freeze, "R1 reset outputs", int'(mem_req), 0);
        @(negedge clk);
        rst = 0;
        #0.5;
        chk(!right_start && !right_act && !ibus_valid, "R1 after reset", int'(right_start), 0);

        // Sequential fetch, stall, delivery
        tick(); left_start = 1; left_hi = 6'd5; #0.5;
        chk(mem_req, "R2 request", int'(mem_req), 1);
        chk(mem_addr == {6'd5, 2'd3}, "R2 address", int'(mem_addr), int'({6'd5, 2'd3}));
        tick(); left_act = 1; expq.push_back(word_of(6'd5)); #0.5;
        chk(right_start && right_hi == 6'd6, "R3 forward with wrap", int'(right_hi), 6);
        tick();
        chk(freeze, "R6 stall while busy", int'(freeze), 1);
        wait_bus("R6 delivery after stall");
        tick();
        chk(right_act, "R7 token to right", int'(right_act), 1);

        // Same address: no new request
        tick(); left_start = 1; left_hi = 6'd9;
        idle(5);
        left_start = 1; left_hi = 6'd9; #0.5;
        chk(!mem_req, "R9 no refetch", int'(mem_req), 0);
        tick(); left_act = 1; expq.push_back(word_of(6'd9)); #0.5;
        chk(right_start && right_hi == 6'd10, "R3 forward on skip", int'(right_hi), 10);
        tick();
        chk(ibus_valid && !freeze, "R7 ready delivery", int'(ibus_valid), 1);
        idle(2);

        // Abort of an in-flight fetch
        tick(); left_start = 1; left_hi = 6'd10;
        tick(); left_start = 1; left_hi = 6'd11; #0.5;
        chk(mem_req && mem_addr[7:2] == 6'd11, "R4 abort reissue", int'(mem_addr[7:2]), 11);
        tick(); left_act = 1; expq.push_back(word_of(6'd11));
        wait_bus("R4 stale response dropped");
        idle(2);

        // Arming: top wins over left, then left ignored
        tick(); top_sel = 1; top_hi = 6'd21; top_label = 2'd1; top_care = 3'b011; top_val = 3'b001;
        left_start = 1; left_hi = 6'd31; #0.5;
        chk(mem_req && mem_addr[7:2] == 6'd21, "R5 top priority", int'(mem_addr[7:2]), 21);
        tick(); left_start = 1; left_hi = 6'd32; #0.5;
        chk(!mem_req, "R5 armed ignores left", int'(mem_req), 0);
        idle(4);

        // Branch: other tag no effect, then pattern mismatch falls back
        jump_valid = 1; jump_label = 2'd2; cond_bits = 3'b000; left_hi = 6'd40; #0.5;
        chk(!mem_req, "R8 other tag ignored", int'(mem_req), 0);
        tick(); jump_valid = 1; jump_label = 2'd1; cond_bits = 3'b000; left_hi = 6'd40; #0.5;
        chk(mem_req && mem_addr[7:2] == 6'd40, "R8 fallback fetch", int'(mem_addr[7:2]), 40);
        tick(); left_start = 1; left_hi = 6'd41; #0.5;
        chk(mem_req, "R8 unarmed again", int'(mem_req), 1);
        idle(5);

        // Pattern match with don't-care bits while busy
        top_sel = 1; top_hi = 6'd22; top_label = 2'd3; top_care = 3'b100; top_val = 3'b100;
        tick(); jump_valid = 1; jump_label = 2'd3; cond_bits = 3'b111;
        expq.push_back(word_of(6'd22));
        tick();
        chk(freeze, "R11 matched target stalls", int'(freeze), 1);
        wait_bus("R11 matched delivery");
        tick();
        chk(right_act, "R7 token after branch target", int'(right_act), 1);

        // Ready target, branch suppresses the token, then unarmed
        tick(); top_sel = 1; top_hi = 6'd23; top_label = 2'd0; top_care = 3'b000; top_val = 3'b000;
        idle(5);
        jump_valid = 1; jump_label = 2'd0; cond_bits = 3'b010; expq.push_back(word_of(6'd23));
        tick();
        chk(ibus_valid && !freeze, "R11 ready target delivers", int'(ibus_valid), 1);
        tick(); jump_valid = 1; jump_label = 2'd2; #0.5;
        chk(!right_act, "R10 branch blocks token", int'(right_act), 0);
        tick(); left_start = 1; left_hi = 6'd50; #0.5;
        chk(mem_req, "R11 unarmed after delivery", int'(mem_req), 1);
        idle(6);

        chk(expq.size() == 0, "R7 all words seen", expq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule